// File: doc/BRIEF.md
# Sleep State Power-Plane Sequencer

This block tracks how deep the system is asleep and drives the active-low controls that shut off power planes. It knows five depths: fully awake (S0), powered-on suspend (S1-M), suspend to RAM (S3), suspend to disk (S4) and soft off (S5). Each depth asserts a nested set of plane controls, so a deeper state always keeps the controls of every shallower state asserted. A suspend-status warning comes on before any plane control, so that attached devices can isolate their outputs first. All plane movement is paced by a slow clock enable, typically 32.768 kHz, and moves one level per enable.

Software-side logic sends a sleep request as a command on a valid/ready channel. The command is taken only while the system is settled awake. While the sequencer is moving or asleep, ready stays low, and the sender must hold valid and the code until ready returns. A debounced power button, generic wake events and a battery-low input control waking. Holding the button long enough forces soft off. An active-low thermal-trip input drives every plane control off at once, with no slow-clock pacing.

Top module: `sleep_plane_seq`

## Requirements
- R1: After reset, every plane control and the suspend-status output are released (high), `state_o` is 0, `req_ready` is 1 and `btn_evt` is 0.
- R2: `state_o` reports the deepest level asserted, using the codes S0=0, S1-M=1, S3=2, S4=3, S5=4. `plane1_n` is low at level 1 and deeper, `plane3_n` at level 2 and deeper, `plane4_n` at level 3 and deeper, and `plane5_n` at level 4 only.
- R3: `req_ready` is high only when the block is settled in S0 and the thermal trip is inactive. When valid and ready are both high on a clock edge, a `req_state` of 1 to 4 selects that target. A code of 0 or 5 to 7 is consumed and has no effect.
- R4: Going deeper advances one step per `slow_tick`, in this order: `sus_stat_n` first, then `plane1_n`, `plane3_n`, `plane4_n` and `plane5_n`. It stops at the target depth.
- R5: Waking releases the controls one per `slow_tick` in the reverse order, and `sus_stat_n` is released last.
- R6: While a sleep target is set, a one-cycle `wake_evt` pulse or a press of the button (a high-to-low edge of `pwr_btn_n`) sets the target back to S0.
- R7: A button press while settled in S0 produces a one-cycle `btn_evt` pulse, visible in the cycle after the edge is sampled, and leaves the state unchanged.
- R8: While `batt_low_n` is low, neither wake events nor button presses wake the system.
- R9: If the button is held low for `OVR_TICKS` consecutive slow ticks, the target becomes S5 from any state. Releasing the button restarts the count.
- R10: After an override, `wake_evt` is ignored, and only a fresh button press wakes the system.
- R11: While `therm_trip_n` is low, all five controls are asserted at the next clock edge with no tick needed, and wake sources are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | Slow clock enable, one cycle wide |
| req_valid | input | 1 | Sleep command valid |
| req_ready | output | 1 | Sleep command ready |
| req_state | input | 3 | Requested depth code |
| pwr_btn_n | input | 1 | Debounced power button, low when pressed |
| therm_trip_n | input | 1 | Thermal trip, active low |
| batt_low_n | input | 1 | Battery low, active low, blocks wake |
| wake_evt | input | 1 | Generic wake event pulse |
| sus_stat_n | output | 1 | Suspend-status warning, active low |
| plane1_n | output | 1 | Plane control for S1-M and deeper |
| plane3_n | output | 1 | Plane control for S3 and deeper |
| plane4_n | output | 1 | Plane control for S4 and deeper |
| plane5_n | output | 1 | Plane control for S5 |
| state_o | output | 3 | Deepest level currently asserted |
| btn_evt | output | 1 | Request pulse for a button press while awake |

## Verification
The hardest situation to reach is a button override that starts from a sleep state. A button press while asleep normally wakes the system before any hold time can build up. The bench therefore first asserts battery-low, which blocks the wake, and then holds the button for the full override count under a shortened `OVR_TICKS`. With the system locked in S5, it checks that wake events are ignored and that only a new press wakes it. A sweep over all eight request codes, with the outputs checked after every tick on the way in and on the way out, covers the ordering of the nested controls.

// File: rtl/slp_seq_pkg.sv
package slp_seq_pkg;
  localparam int NPLANE = 4;
  localparam int STEP_W = $clog2(NPLANE + 2);

  typedef enum logic [2:0] {
    ST_S0  = 3'd0,
    ST_S1M = 3'd1,
    ST_S3  = 3'd2,
    ST_S4  = 3'd3,
    ST_S5  = 3'd4
  } slp_state_e;

  // Step 0: nothing asserted; step 1: warning only; step n>1: planes up to n-1
  function automatic logic [STEP_W-1:0] state_to_step(slp_state_e s);
    return (s == ST_S0) ? '0 : STEP_W'(s) + STEP_W'(1);
  endfunction
endpackage

// File: rtl/ovr_hold_timer.sv
module ovr_hold_timer #(
  parameter int OVR_TICKS = 131072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic held,
  output logic fire
);
  localparam int CW = $clog2(OVR_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(OVR_TICKS - 1);
  localparam logic [CW-1:0] SAT  = CW'(OVR_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !held) begin
      cnt <= '0;
    end else if (tick && cnt != SAT) begin
      cnt <= cnt + CW'(1);
    end
  end

  // one pulse per hold: the counter saturates after the firing tick
  assign fire = held && tick && (cnt == LAST);
endmodule

// File: rtl/plane_stepper.sv
module plane_stepper
  import slp_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              force_deep,
  input  logic [STEP_W-1:0] tgt_step,
  output logic [STEP_W-1:0] step,
  output logic              warn_n,
  output logic [NPLANE-1:0] plane_n,
  output logic [2:0]        depth
);
  localparam logic [STEP_W-1:0] TOP = STEP_W'(NPLANE + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0;
    end else if (force_deep) begin
      step <= TOP;
    end else if (tick && step < tgt_step) begin
      step <= step + STEP_W'(1);
    end else if (tick && step > tgt_step) begin
      step <= step - STEP_W'(1);
    end
  end

  assign warn_n = (step == '0);

  for (genvar i = 0; i < NPLANE; i++) begin : g_plane
    assign plane_n[i] = !(step >= STEP_W'(i + 2));
  end

  assign depth = (step <= STEP_W'(1)) ? 3'd0 : 3'(step - STEP_W'(1));
endmodule

// File: rtl/sleep_plane_seq.sv
module sleep_plane_seq
  import slp_seq_pkg::*;
#(
  parameter int OVR_TICKS = 131072
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [2:0] req_state,
  input  logic       pwr_btn_n,
  input  logic       therm_trip_n,
  input  logic       batt_low_n,
  input  logic       wake_evt,
  output logic       sus_stat_n,
  output logic       plane1_n,
  output logic       plane3_n,
  output logic       plane4_n,
  output logic       plane5_n,
  output logic [2:0] state_o,
  output logic       btn_evt
);
  slp_state_e        tgt;
  logic              lock_q;
  logic              btn_q;
  logic              press;
  logic              ovr_fire;
  logic              wake_ok;
  logic              code_ok;
  logic [STEP_W-1:0] step;
  logic [NPLANE-1:0] plane_n;

  assign press   = btn_q && !pwr_btn_n;
  assign wake_ok = batt_low_n && (press || (wake_evt && !lock_q));
  assign code_ok = (req_state != 3'd0) && (req_state <= 3'd4);
  assign req_ready = (tgt == ST_S0) && (step == '0) && therm_trip_n;

  ovr_hold_timer #(.OVR_TICKS(OVR_TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (slow_tick),
    .held  (!pwr_btn_n),
    .fire  (ovr_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt     <= ST_S0;
      lock_q  <= 1'b0;
      btn_q   <= 1'b1;
      btn_evt <= 1'b0;
    end else begin
      btn_q   <= pwr_btn_n;
      btn_evt <= press && (tgt == ST_S0) && (step == '0) && therm_trip_n;
      if (!therm_trip_n) begin
        tgt <= ST_S5;
      end else if (ovr_fire) begin
        tgt    <= ST_S5;
        lock_q <= 1'b1;
      end else if (tgt != ST_S0 && wake_ok) begin
        tgt    <= ST_S0;
        lock_q <= 1'b0;
      end else if (req_valid && req_ready && code_ok) begin
        tgt <= slp_state_e'(req_state);
      end
    end
  end

  plane_stepper u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (slow_tick),
    .force_deep (!therm_trip_n),
    .tgt_step   (state_to_step(tgt)),
    .step       (step),
    .warn_n     (sus_stat_n),
    .plane_n    (plane_n),
    .depth      (state_o)
  );

  assign plane1_n = plane_n[0];
  assign plane3_n = plane_n[1];
  assign plane4_n = plane_n[2];
  assign plane5_n = plane_n[3];
endmodule

// File: rtl/sleep_plane_seq_chk.sv
module sleep_plane_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slow_tick,
  input logic       req_ready,
  input logic       therm_trip_n,
  input logic       sus_stat_n,
  input logic       plane1_n,
  input logic       plane3_n,
  input logic       plane4_n,
  input logic       plane5_n,
  input logic [2:0] state_o,
  input logic       btn_evt
);
  // R2
  nested_planes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!plane5_n |-> !plane4_n) and (!plane4_n |-> !plane3_n) and
    (!plane3_n |-> !plane1_n) and (!plane1_n |-> !sus_stat_n));

  // R11
  thermal_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !therm_trip_n |=> (!plane5_n && state_o == 3'd4));

  // R4
  tick_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow_tick && therm_trip_n) |=>
      $stable({sus_stat_n, plane1_n, plane3_n, plane4_n, plane5_n}));

  // R3
  ready_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sus_stat_n && plane1_n && state_o == 3'd0));

  // R7
  btn_evt_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btn_evt |-> (sus_stat_n || !$past(therm_trip_n)));
endmodule

bind sleep_plane_seq sleep_plane_seq_chk u_chk (.*);

// File: tb/tb_sleep_plane_seq.sv
module tb_sleep_plane_seq;
  logic clk = 0, rst_n = 0, slow_tick = 0, req_valid = 0;
  logic [2:0] req_state = 0;
  logic pwr_btn_n = 1, therm_trip_n = 1, batt_low_n = 1, wake_evt = 0;
  logic req_ready, sus_stat_n, plane1_n, plane3_n, plane4_n, plane5_n, btn_evt;
  logic [2:0] state_o;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sleep_plane_seq #(.OVR_TICKS(8)) dut (.*);

  // expected outputs for step e: warning, planes, depth code
  task automatic chk_step(int e, string req);
    logic [7:0] exp_v, act_v;
    exp_v = {e < 1, e < 2, e < 3, e < 4, e < 5, 3'((e <= 1) ? 0 : e - 1)};
    act_v = {sus_stat_n, plane1_n, plane3_n, plane4_n, plane5_n, state_o};
    total++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b", req, act_v, exp_v);
    end
  endtask

  task automatic chk_bit(logic act, logic exp_b, string req);
    total++;
    if (act !== exp_b) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp_b);
    end
  endtask

  task automatic tick1();
    slow_tick = 1; @(posedge clk); @(negedge clk); slow_tick = 0;
  endtask

  task automatic pulse_wake();
    wake_evt = 1; @(posedge clk); @(negedge clk); wake_evt = 0;
  endtask

  task automatic press_release();
    pwr_btn_n = 0; @(posedge clk); @(negedge clk); pwr_btn_n = 1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic request(int code);
    req_valid = 1; req_state = 3'(code);
    @(posedge clk); @(negedge clk); req_valid = 0;
  endtask

  task automatic settle_down(int from);
    for (int k = 1; k <= from; k++) begin tick1(); chk_step(from - k, "R5"); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_step(0, "R1");
    chk_bit(req_ready, 1, "R1 ready");
    chk_bit(btn_evt, 0, "R1 btn_evt");

    // R2 R3 R4 R5: sweep every request code in and out
    for (int c = 0; c < 8; c++) begin
      int ts;
      ts = (c >= 1 && c <= 4) ? c + 1 : 0;
      chk_bit(req_ready, 1, "R3 ready before");
      request(c);
      chk_bit(req_ready, ts == 0, "R3 ready after");
      for (int k = 1; k <= 6; k++) begin
        tick1(); chk_step((k < ts) ? k : ts, "R2/R4");
      end
      if (ts != 0) begin
        pulse_wake();
        chk_step(ts, "R5 before tick");
        for (int k = 1; k <= 6; k++) begin
          tick1(); chk_step((ts - k > 0) ? ts - k : 0, "R5");
        end
      end
      chk_bit(req_ready, 1, "R3 back");
    end

    // R7: press while awake
    pwr_btn_n = 0; @(posedge clk); @(negedge clk);
    chk_bit(btn_evt, 1, "R7 pulse");
    @(posedge clk); @(negedge clk);
    chk_bit(btn_evt, 0, "R7 one cycle");
    pwr_btn_n = 1;
    chk_step(0, "R7 state");
    chk_bit(req_ready, 1, "R7 ready");

    // R6: button wakes from S1-M
    request(1); tick1(); tick1(); chk_step(2, "R6 entered");
    press_release();
    tick1(); tick1(); chk_step(0, "R6 button wake");

    // R8: battery low blocks wake
    request(2); repeat (3) tick1(); chk_step(3, "R8 entered");
    batt_low_n = 0;
    pulse_wake(); tick1(); tick1(); chk_step(3, "R8 wake_evt blocked");
    press_release(); tick1(); chk_step(3, "R8 press blocked");

    // R9: override from S3 while wake is blocked
    pwr_btn_n = 0;
    repeat (7) tick1();
    chk_step(3, "R9 7 ticks");
    tick1(); chk_step(3, "R9 8th tick");
    tick1(); chk_step(4, "R9 deeper");
    tick1(); chk_step(5, "R9 S5");
    pwr_btn_n = 1; batt_low_n = 1;
    @(negedge clk);

    // R10: only a fresh press wakes after override
    pulse_wake(); tick1(); tick1(); chk_step(5, "R10 wake_evt ignored");
    press_release();
    settle_down(5);

    // R9: release restarts the count (from S0)
    pwr_btn_n = 0; repeat (5) tick1(); pwr_btn_n = 1; @(negedge clk);
    pwr_btn_n = 0; repeat (7) tick1();
    chk_bit(req_ready, 1, "R9 restart no override");
    tick1();
    chk_bit(req_ready, 0, "R9 override fired");
    pwr_btn_n = 1;
    repeat (5) tick1(); chk_step(5, "R9 S5 from S0");
    press_release(); settle_down(5);

    // R11: thermal trip from S0 and mid-entry
    therm_trip_n = 0; @(posedge clk); @(negedge clk);
    chk_step(5, "R11 immediate");
    chk_bit(req_ready, 0, "R11 ready");
    pulse_wake(); press_release(); chk_step(5, "R11 wake ignored");
    therm_trip_n = 1; @(negedge clk);
    pulse_wake(); settle_down(5);
    request(3); tick1(); chk_step(1, "R11 mid entry");
    therm_trip_n = 0; @(posedge clk); @(negedge clk);
    chk_step(5, "R11 from mid entry");
    therm_trip_n = 1; @(negedge clk);
    pulse_wake(); settle_down(5);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule